// File: doc/BRIEF.md
# Input Power Monitor

The block watches a stream of signed converter samples and condenses each observation window into one 24-bit result held in a read-only holding register. Two modes are offered. Peak mode keeps the largest sample magnitude that rose above an upper threshold. Count mode counts the samples whose magnitude rose above that threshold. The threshold is a configuration input that the surrounding logic shares with the gain-control path.

The holding register can be refreshed from two sources. The first is a free-running period timer that closes a window every programmed number of clock cycles, and it can raise a one-cycle interrupt at each window end. The second applies when the timer is switched off: a read strobe from the register interface loads the current result. In that case the accumulation can optionally restart after every read.

Samples arrive on a valid/ready interface. The block never applies back-pressure. `s_ready` is held high from the first clock after reset, and a sample is consumed on every rising edge where `s_valid` and `s_ready` are both high. The upstream side may therefore present a sample on any cycle, and a cycle with `s_valid` low carries no sample.

Top module: `input_power_monitor`

## Requirements
- R1: After reset, `hold_value` is 0, `irq` is 0 and `s_ready` is 1 from the first clock edge on.
- R2: With `cfg_enable` high and `cfg_timer_off` low, the window counter starts from zero on the first enabled cycle. `hold_value` is loaded on every `cfg_period`-th enabled rising edge and changes on no other edge. The loaded value includes the sample accepted on that same edge.
- R3: When `cfg_mode` is 0 (peak), the result is the largest two's-complement magnitude among accepted samples whose magnitude is strictly greater than the zero-extended `cfg_upper_thr`, or 0 if there are none. The most negative code gives 2^(SAMPLE_W-1).
- R4: When `cfg_mode` is 1 (count), the result is the number of accepted samples whose magnitude is strictly greater than `cfg_upper_thr`, saturating at 2^24-1. A magnitude equal to the threshold is not counted.
- R5: At each timer-driven load the accumulation restarts from zero, so no sample from one window contributes to the next.
- R6: When `cfg_irq_en` is high, `irq` pulses high for exactly one cycle, in the same cycle that the timer-driven load becomes visible. When `cfg_irq_en` is low, `irq` stays 0 while loads still occur.
- R7: With `cfg_timer_off` high, `hold_value` changes only on an edge where `rd_strobe` is high. It then takes the accumulation, including the sample accepted on that edge.
- R8: With `cfg_timer_off` high and `cfg_clear_on_read` high, the accumulation restarts from zero after each read. With `cfg_clear_on_read` low, it continues across reads.
- R9: With `cfg_timer_off` low, `rd_strobe` changes neither `hold_value` nor the accumulation, whatever `cfg_clear_on_read` holds.
- R10: Cycles with `s_valid` low contribute nothing to the result in either mode.
- R11: A `cfg_period` of 0 behaves as a period of 1, so a load occurs on every enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample present this cycle |
| s_ready | output | 1 | Always 1 after reset; no back-pressure |
| s_sample | input | SAMPLE_W | Signed two's-complement sample |
| cfg_enable | input | 1 | Monitor enable; low clears counter and accumulation, keeps the holding value |
| cfg_mode | input | 1 | 0 = peak magnitude, 1 = threshold-crossing count |
| cfg_period | input | HOLD_W | Window length in clock cycles (0 acts as 1) |
| cfg_upper_thr | input | THR_W | Upper magnitude threshold |
| cfg_timer_off | input | 1 | 1 = loads come from reads instead of the timer |
| cfg_clear_on_read | input | 1 | 1 = a read-driven load restarts the accumulation |
| cfg_irq_en | input | 1 | Enables the window-end interrupt pulse |
| rd_strobe | input | 1 | Read of the holding register |
| hold_value | output | HOLD_W | Holding register |
| irq | output | 1 | One-cycle window-end pulse |

## Verification
The embedded properties check on every cycle that the holding value moves only on a timer tick or an accepted read, that the interrupt follows a tick with the enable set, that the window counter returns to zero after each tick, and that the accumulation never falls between clears and stays pinned once it saturates. Only the directed scenarios can show that the numbers are right. Those are the peak and count results for mixed-sign samples against the threshold, the exact edge on which each window closes, the exclusion of invalid cycles, and the read-driven loads with and without clear-on-read.

// File: rtl/ipm_pkg.sv
package ipm_pkg;
  localparam int unsigned IPM_HOLD_W = 24;

  typedef enum logic {
    IPM_PEAK  = 1'b0,
    IPM_COUNT = 1'b1
  } ipm_mode_e;
endpackage

// File: rtl/ipm_magnitude.sv
module ipm_magnitude #(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned THR_W    = 10
) (
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [THR_W-1:0]    thr,
  output logic [SAMPLE_W-1:0] mag,
  output logic                hit
);
  // Unsigned magnitude: the most negative code maps to 2^(SAMPLE_W-1).
  always_comb begin
    mag = sample[SAMPLE_W-1] ? (~sample + 1'b1) : sample;
    hit = s_valid && (mag > SAMPLE_W'(thr));
  end
endmodule

// File: rtl/ipm_period_timer.sv
module ipm_period_timer #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;

  always_comb begin
    // A period of 0 behaves as 1 (R11).
    last_idx = (period == '0) ? '0 : period - 1'b1;
    tick     = run && (cnt_q >= last_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R2 / R5: every window starts its count from zero after a tick.
  p_cnt_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/ipm_accum.sv
module ipm_accum
  import ipm_pkg::*;
#(
  parameter int unsigned MAG_W  = 14,
  parameter int unsigned HOLD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  ipm_mode_e         mode,
  input  logic              hit,
  input  logic [MAG_W-1:0]  mag,
  input  logic              clear,
  output logic [HOLD_W-1:0] acc_next
);
  localparam logic [HOLD_W-1:0] ACC_MAX = '1;

  logic [HOLD_W-1:0] acc_q;
  logic [HOLD_W-1:0] mag_ext;

  always_comb begin
    mag_ext  = HOLD_W'(mag);
    acc_next = acc_q;
    if (hit) begin
      if (mode == IPM_PEAK) begin
        if (mag_ext > acc_q) acc_next = mag_ext;
      end else if (acc_q != ACC_MAX) begin
        acc_next = acc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable || clear) acc_q <= '0;
    else                            acc_q <= acc_next;
  end

  // R3 / R4: the accumulation never falls between clears.
  p_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !clear) |=> (acc_q >= $past(acc_q)));

  // R4: a saturated count stays saturated.
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !clear && mode == IPM_COUNT && acc_q == ACC_MAX) |=> (acc_q == ACC_MAX));
endmodule

// File: rtl/input_power_monitor.sv
module input_power_monitor
  import ipm_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned THR_W    = 10,
  parameter int unsigned HOLD_W   = IPM_HOLD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_sample,
  input  logic                cfg_enable,
  input  logic                cfg_mode,
  input  logic [HOLD_W-1:0]   cfg_period,
  input  logic [THR_W-1:0]    cfg_upper_thr,
  input  logic                cfg_timer_off,
  input  logic                cfg_clear_on_read,
  input  logic                cfg_irq_en,
  input  logic                rd_strobe,
  output logic [HOLD_W-1:0]   hold_value,
  output logic                irq
);
  logic [SAMPLE_W-1:0] mag;
  logic                hit;
  logic                tick;
  logic                rd_load;
  logic                load;
  logic                acc_clr;
  logic [HOLD_W-1:0]   acc_next;
  logic                ready_q;
  ipm_mode_e           mode;

  assign mode    = ipm_mode_e'(cfg_mode);
  assign s_ready = ready_q;

  ipm_magnitude #(.SAMPLE_W(SAMPLE_W), .THR_W(THR_W)) u_mag (
    .s_valid (s_valid && ready_q),
    .sample  (s_sample),
    .thr     (cfg_upper_thr),
    .mag     (mag),
    .hit     (hit)
  );

  ipm_period_timer #(.CNT_W(HOLD_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (cfg_enable && !cfg_timer_off),
    .period (cfg_period),
    .tick   (tick)
  );

  always_comb begin
    rd_load = cfg_enable && cfg_timer_off && rd_strobe;
    load    = tick || rd_load;
    acc_clr = tick || (rd_load && cfg_clear_on_read);
  end

  ipm_accum #(.MAG_W(SAMPLE_W), .HOLD_W(HOLD_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (cfg_enable),
    .mode     (mode),
    .hit      (hit),
    .mag      (mag),
    .clear    (acc_clr),
    .acc_next (acc_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_value <= '0;
      irq        <= 1'b0;
      ready_q    <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      irq     <= tick && cfg_irq_en;
      if (load) hold_value <= acc_next;
    end
  end

  // R2 / R7: the holding value moves only on a tick or an accepted read.
  p_hold_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hold_value) |-> $past(load));

  // R6: the interrupt follows a tick with the enable set.
  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(tick) && $past(cfg_irq_en)));

  // R1: ready is asserted from the first edge after reset.
  p_ready_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> s_ready);
endmodule

// File: tb/input_power_monitor_bench.sv
module input_power_monitor_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [13:0] s_sample = '0;
  logic        cfg_enable = 1'b0;
  logic        cfg_mode = 1'b0;
  logic [23:0] cfg_period = 24'd5;
  logic [9:0]  cfg_upper_thr = 10'd100;
  logic        cfg_timer_off = 1'b0;
  logic        cfg_clear_on_read = 1'b0;
  logic        cfg_irq_en = 1'b0;
  logic        rd_strobe = 1'b0;
  logic [23:0] hold_value;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  input_power_monitor u_input_power_monitor (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_sample(s_sample), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
    .cfg_period(cfg_period), .cfg_upper_thr(cfg_upper_thr),
    .cfg_timer_off(cfg_timer_off), .cfg_clear_on_read(cfg_clear_on_read),
    .cfg_irq_en(cfg_irq_en), .rd_strobe(rd_strobe),
    .hold_value(hold_value), .irq(irq)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present one cycle of input; returns at the falling edge after it was consumed.
  task automatic drive(input logic v, input int x, input logic rd = 1'b0);
    s_valid   = v;
    s_sample  = 14'(x);
    rd_strobe = rd;
    @(negedge clk);
  endtask

  task automatic restart(input logic mode, input int period, input int thr,
                         input logic toff, input logic clr, input logic ien);
    cfg_enable = 1'b0;
    drive(1'b0, 0);
    cfg_mode = mode; cfg_period = 24'(period); cfg_upper_thr = 10'(thr);
    cfg_timer_off = toff; cfg_clear_on_read = clr; cfg_irq_en = ien;
    cfg_enable = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 hold", hold_value, 24'd0);
    check("R1 irq", {23'd0, irq}, 24'd0);
    check("R1 ready", {23'd0, s_ready}, 24'd1);
  endtask

  task automatic t_peak();
    restart(1'b0, 5, 100, 1'b0, 1'b0, 1'b1);
    drive(1'b1, 50);
    drive(1'b1, -300);
    drive(1'b1, 200);
    drive(1'b1, 100);
    check("R2 no early load", hold_value, 24'd0);
    drive(1'b1, 7);
    check("R3 peak window", hold_value, 24'd300);
    check("R6 irq pulse", {23'd0, irq}, 24'd1);
    drive(1'b1, 101);
    check("R6 irq one cycle", {23'd0, irq}, 24'd0);
    drive(1'b0, 5000);
    drive(1'b1, -102);
    drive(1'b1, 0);
    check("R2 hold steady mid-window", hold_value, 24'd300);
    drive(1'b1, -8192);
    check("R3 most negative", hold_value, 24'd8192);
    drive(1'b1, 101); drive(1'b0, 6000); drive(1'b1, -102); drive(1'b1, 3); drive(1'b1, 1);
    check("R5 R10 new window peak", hold_value, 24'd102);
  endtask

  task automatic t_count();
    restart(1'b1, 5, 100, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 150);
    drive(1'b1, -150);
    drive(1'b1, 100);
    drive(1'b0, 900);
    drive(1'b1, -101);
    check("R4 count", hold_value, 24'd3);
    check("R6 no irq when disabled", {23'd0, irq}, 24'd0);
  endtask

  task automatic t_read_mode();
    restart(1'b1, 2, 10, 1'b1, 1'b0, 1'b1);
    drive(1'b1, 20);
    drive(1'b1, 30);
    drive(1'b1, 40, 1'b1);
    check("R7 read load", hold_value, 24'd3);
    drive(1'b1, 50);
    for (int i = 0; i < 6; i++) drive(1'b0, 0);
    check("R7 no timer load", hold_value, 24'd3);
    check("R7 no irq", {23'd0, irq}, 24'd0);
    drive(1'b1, 0, 1'b1);
    check("R8 no clear keeps count", hold_value, 24'd4);
    cfg_clear_on_read = 1'b1;
    drive(1'b1, 60, 1'b1);
    check("R8 read before clear", hold_value, 24'd5);
    drive(1'b1, 70);
    drive(1'b1, 0, 1'b1);
    check("R8 cleared after read", hold_value, 24'd1);
  endtask

  task automatic t_read_ignored();
    restart(1'b1, 4, 10, 1'b0, 1'b1, 1'b0);
    drive(1'b1, 20);
    drive(1'b1, 20, 1'b1);
    check("R9 read ignored", hold_value, 24'd1);
    drive(1'b1, 20);
    drive(1'b1, 20);
    check("R9 accumulation kept", hold_value, 24'd4);
  endtask

  task automatic t_period_zero();
    restart(1'b1, 0, 10, 1'b0, 1'b0, 1'b1);
    drive(1'b1, 20);
    check("R11 load each cycle", hold_value, 24'd1);
    check("R11 irq", {23'd0, irq}, 24'd1);
    drive(1'b1, 5);
    check("R11 next cycle", hold_value, 24'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_peak();
    t_count();
    t_read_mode();
    t_read_ignored();
    t_period_zero();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule